// File: doc/BRIEF.md
# Latched Wide Timestamp Counter

A free-running up-counter, 40 bits wide by default, that serves as a system time base. Software reads it through a data bus narrower than the count, in two accesses. Reading the low-word register returns the low bits of the count. On the same clock edge it copies the remaining upper bits into a shadow byte. A later read of the high-word register returns that shadow byte, so the two halves always belong to one instant, even if the count carries between the accesses.

The counter advances by one on each cycle in which the tick-enable input is high and counting is enabled. That input is a strobe at the time-base rate, nominally 983.04 kHz, produced outside this block. Counting is switched on and off through one bit of the high-word register, and that bit reads back the present state. The block raises no interrupt. At its top value the count wraps to zero without notice. Read data is registered and appears one cycle after the read request.

Top module: `tstamp_latch_counter`

## Requirements
- R1: After reset the count is zero, counting is disabled and the shadow byte is zero, so reads of both registers return zero.
- R2: While counting is enabled, the count rises by exactly one for each clock cycle in which `tick_i` is high, and it does not change in cycles where `tick_i` is low.
- R3: While counting is disabled, the count holds its value whatever `tick_i` does.
- R4: A read of the low-word register (`addr_i` = 0x60) returns count bits DATA_W-1:0, as they stood at the request edge, on `rdata_o` in the following cycle. In a cycle after one with no read request, `rdata_o` is zero.
- R5: A low-word read copies count bits CNT_W-1:DATA_W into the shadow byte at the same edge. A read of the high-word register (`addr_i` = 0x64) returns the shadow byte in bits CNT_W-DATA_W-1:0, so a low read followed by a high read gives one consistent full-width value.
- R6: A high-word read that has no new low-word read before it returns the byte captured by the last low-word read, not the live upper count bits.
- R7: In high-word read data, bit 8 shows the current enable state and every bit above the shadow byte other than bit 8 is zero.
- R8: A write to the high-word register sets counting enabled when bit 8 of the write data is 1 and disabled when it is 0. All other write data bits are ignored. Writes to the low-word register or to any other offset change nothing.
- R9: When the count is at its all-ones value and advances, it wraps to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base strobe; one count step per high cycle when enabled |
| rd_en_i | input | 1 | Read request for the register at `addr_i` |
| wr_en_i | input | 1 | Write request for the register at `addr_i` |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data; bit 8 is the enable in the high-word register |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after the request |

## Verification
The hardest cases to reach are a carry into the upper bits between the two halves of a read and the silent wrap at full width. Neither can be reached in a 40-bit count within a bench run, because the count cannot be preloaded from the ports. The bench therefore also drives a second instance with a 16-bit count and a 12-bit data word. In that instance the shadow nibble changes every 4096 ticks, and the whole count wraps after 65536 ticks. A pair of reads is taken before and after a 66000-cycle run, and a stale high read is taken after more than 4096 ticks have passed. A behavioural model of both instances is compared with `rdata_o` on every clock, including stretches where `tick_i` is random.

// File: rtl/tstamp_latch_counter.sv
module tstamp_latch_counter #(
  parameter int CNT_W  = 40,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HI_W-1:0]   snap_q;
  logic              run_q;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] rd_mux;

  wire lo_hit = (addr_i == LO_ADDR);
  wire hi_hit = (addr_i == HI_ADDR);
  wire adv    = run_q && tick_i;
  wire grab   = rd_en_i && lo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    snap_q <= '0;
    else if (grab) snap_q <= cnt_q[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_q <= 1'b0;
    else if (wr_en_i && hi_hit)  run_q <= wdata_i[EN_BIT];
  end

  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = snap_q;
    hi_word[EN_BIT] = run_q;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_en_i) begin
      if (lo_hit)      rd_mux = cnt_q[DATA_W-1:0];
      else if (hi_hit) rd_mux = hi_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_mux;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i) |=> (cnt_q == $past(cnt_q) + STEP));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && tick_i) |=> $stable(cnt_q));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (rdata_o == '0));

  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == LO_ADDR) |=> (snap_q == $past(cnt_q[CNT_W-1:DATA_W])));

  a_r6_shadow_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && addr_i == LO_ADDR) |=> $stable(snap_q));

  a_r8_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == HI_ADDR) |=> (run_q == $past(wdata_i[EN_BIT])));

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: tb/sim_tstamp_latch_counter.sv
`timescale 1ns/1ps
module sim_tstamp_latch_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0;
  logic [11:0] rdata1;
  int n_cmp = 0, n_bad = 0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  tstamp_latch_counter u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0));

  tstamp_latch_counter #(.CNT_W(16), .DATA_W(12)) u1 (.clk(clk), .rst_n(rst_n),
    .tick_i(tick), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata[11:0]), .rdata_o(rdata1));

  longint m_cnt[2], m_rd[2], m_sh[2];
  bit     m_en[2];
  string  m_tag[2];
  int     CW[2] = '{40, 16};
  int     DW[2] = '{32, 12};

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      longint dm, hm, cm, nrd;
      bit old_en;
      dm = (longint'(1) << DW[i]) - 1;
      hm = (longint'(1) << (CW[i] - DW[i])) - 1;
      cm = (longint'(1) << CW[i]) - 1;
      if (!rst_n) begin
        m_cnt[i] = 0; m_sh[i] = 0; m_en[i] = 0; m_rd[i] = 0; m_tag[i] = "R1";
      end else begin
        nrd = 0; m_tag[i] = "R4";
        if (rd_en && addr == 8'h60) begin
          nrd = m_cnt[i] & dm;
          m_sh[i] = (m_cnt[i] >> DW[i]) & hm;
        end else if (rd_en && addr == 8'h64) begin
          nrd = (longint'(m_en[i]) << 8) | m_sh[i];
          m_tag[i] = "R5";
        end
        old_en = m_en[i];
        if (wr_en && addr == 8'h64) m_en[i] = wdata[8];
        if (old_en && tick) m_cnt[i] = (m_cnt[i] + 1) & cm;
        m_rd[i] = nrd;
      end
    end
  end

  always @(negedge clk) if (live) begin
    n_cmp += 2;
    if (longint'(rdata0) != m_rd[0]) begin
      n_bad++;
      $display("FAIL %s u0 rdata got %h expected %h", m_tag[0], rdata0, m_rd[0]);
    end
    if (longint'(rdata1) != m_rd[1]) begin
      n_bad++;
      $display("FAIL %s u1 rdata got %h expected %h", m_tag[1], rdata1, m_rd[1]);
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output longint v0, output longint v1);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = 8'h00;
    v0 = rdata0; v1 = rdata1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    longint a0, a1, b0, b1, h0, h1, g0, g1, l0, l1, v1, v2;
    idle(3);
    rst_n = 1'b1; live = 1'b1;
    idle(2);
    // R1: everything zero after reset
    rd(8'h60, a0, a1); chk("R1 lo", a0, 0); chk("R1 lo u1", a1, 0);
    rd(8'h64, a0, a1); chk("R1 hi", a0, 0); chk("R1 hi u1", a1, 0);
    // R3: disabled counter ignores ticks
    tick = 1'b1; idle(5);
    rd(8'h60, a0, a1); chk("R3 hold", a0, 0);
    // R7: enable reads back in bit 8
    wr(8'h64, 32'h0000_0100);
    rd(8'h64, a0, a1); chk("R7 en", a0, 32'h100); chk("R7 en u1", a1, 12'h100);
    // R2: one step per ticking cycle
    rd(8'h60, a0, a1); idle(9); rd(8'h60, b0, b1);
    chk("R2 step", b0 - a0, 10);
    // R2: random tick pattern, checked by the model each cycle
    for (int k = 0; k < 300; k++) begin tick = 1'($urandom); idle(1); end
    tick = 1'b1;
    // R6 and R5: stale shadow, consistent pairs across a carry
    rd(8'h60, l0, l1); rd(8'h64, h0, h1);
    idle(5000);
    rd(8'h64, g0, g1); chk("R6 stale hi", g1, h1); chk("R6 stale hi u0", g0, h0);
    rd(8'h60, a0, a1); rd(8'h64, b0, b1);
    v1 = ((h1 & 15) << 12) | l1; v2 = ((b1 & 15) << 12) | a1;
    chk("R5 pair", v2, (v1 + 5003) & 16'hFFFF);
    chk("R4 lo diff", a0, l0 + 5003);
    // R8: disable with other bits set, R7 upper bits zero
    wr(8'h64, 32'hFFFF_FEFF);
    rd(8'h64, a0, a1); chk("R7 upper zero", a0 & 32'hFFFF_FF00, 0);
    rd(8'h60, l0, l1); idle(20); rd(8'h60, b0, b1); chk("R8 disabled", b0, l0);
    wr(8'h60, 32'h1234_5678); wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h64, a0, a1); chk("R8 ignored writes", a0 & 32'h100, 0);
    rd(8'h60, b0, b1); chk("R8 count kept", b0, l0);
    wr(8'h64, 32'h0000_0100);
    // R9: wrap of the narrow instance
    rd(8'h60, l0, l1); rd(8'h64, h0, h1);
    v1 = ((h1 & 15) << 12) | l1;
    idle(66000);
    rd(8'h60, a0, a1); rd(8'h64, b0, b1);
    v2 = ((b1 & 15) << 12) | a1;
    chk("R9 wrap", v2, (v1 + 66002) & 16'hFFFF);
    chk("R9 wide no wrap", a0, l0 + 66002);
    idle(4);
    summary();
  end
endmodule